// File: doc/BRIEF.md
# Packed Lane Saturating Add/Subtract Unit

This unit adds or subtracts two 64-bit operands that are split into independent packed lanes. The caller picks the lane size for each operation: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. It also picks whether the lanes hold signed or unsigned numbers. No carry or borrow ever passes from one lane into the next, so every lane behaves like a separate adder of its own width.

Each operation runs in one of two modes. In clamp mode, a lane whose exact result falls outside its type's range is pinned to the nearest limit of that range. In wrap mode, the lane keeps only its low bits. In both modes the unit reports a per-byte flag that marks which lanes went out of range. The result is registered: an accepted operand pair produces its result and flags one clock later, together with a single-cycle valid pulse.

Top module: `simd_sat_addsub`

## Requirements
- R1: `lane_size` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give 32-bit lanes. Lane i occupies bits [i*n+n-1 : i*n] of the operands and the result. No carry or borrow crosses a lane boundary.
- R2: With `op_sat`=0 (wrap mode), each result lane equals the low n bits of the exact sum (`op_sub`=0) or exact difference (`op_sub`=1) of the two lanes.
- R3: With `op_sat`=1, `op_signed`=0 and `op_sub`=0, a lane whose sum exceeds 2^n-1 gives all ones.
- R4: With `op_sat`=1, `op_signed`=0 and `op_sub`=1, a lane whose difference is below zero gives zero.
- R5: With `op_sat`=1 and `op_signed`=1, the lanes are two's complement. A result above 2^(n-1)-1 gives that value. A result below -2^(n-1) gives -2^(n-1).
- R6: `out_flags` has one bit per byte position. A bit is 1 exactly when the exact result of the lane containing that byte lay outside the lane type's range. This holds in both clamp and wrap mode, so every flag bit of one lane has the same value.
- R7: A sample taken with `in_valid`=1 at a rising edge appears on `out_result` and `out_flags`, with `out_valid`=1, right after that edge. `out_valid` is 0 after an edge where `in_valid`=0, and the result and flags then hold their previous values.
- R8: A synchronous active-high `rst` clears `out_valid`, `out_result` and `out_flags` to zero.
- R9: In clamp mode, an in-range lane gives the same result as wrap mode. For example, unsigned bytes 78h+05h give 7Dh, while FEh+34h and EDh+56h both give FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opa | input | 64 | First operand (minuend when subtracting) |
| opb | input | 64 | Second operand (subtrahend when subtracting) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_signed | input | 1 | 1 = lanes are two's complement |
| op_sat | input | 1 | 1 = clamp to lane limits, 0 = wrap |
| lane_size | input | 2 | Lane width code: 0 = 8, 1 = 16, 2 or 3 = 32 |
| out_valid | output | 1 | Result registered from an accepted input |
| out_result | output | 64 | Packed result lanes |
| out_flags | output | 8 | Out-of-range flag, one bit per byte position |

## Verification
Within one operation, some lanes can clamp while neighbouring lanes stay in range or wrap. The bench provokes this with directed vectors that put a lane at a range limit next to an in-range lane. One example is a 32-bit borrow out of the low lane next to a small upper lane. Another is the FEh/EDh/78h byte triple. Thousands of random vectors across all sizes and modes follow. Each lane's result and each byte flag are judged against a reference model that does the arithmetic in 64-bit integers, so any leak across a lane boundary or a clamp to the wrong limit shows up as a mismatch in a specific lane.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        LSZ_8   = 2'd0,
        LSZ_16  = 2'd1,
        LSZ_32  = 2'd2,
        LSZ_32B = 2'd3
    } lane_size_e;

    localparam int unsigned NUM_SIZES = 3;

    function automatic int unsigned size_width(input int unsigned idx);
        return 8 << idx;
    endfunction

endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sgn,
    input  logic         sat,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic [W:0]   ext;
    logic [W-1:0] wrap_val;
    logic [W-1:0] clamp_val;
    logic         b_sign_eff;

    always_comb begin
        ext        = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        wrap_val   = ext[W-1:0];
        b_sign_eff = sub ? ~b[W-1] : b[W-1];
        if (sgn) begin
            // same effective signs in, different sign out
            ovf       = (a[W-1] == b_sign_eff) && (wrap_val[W-1] != a[W-1]);
            clamp_val = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            ovf       = ext[W];
            clamp_val = sub ? {W{1'b0}} : {W{1'b1}};
        end
        res = (sat && ovf) ? clamp_val : wrap_val;
    end

endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8
) (
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                sub,
    input  logic                sgn,
    input  logic                sat,
    output logic [DATA_W-1:0]   res,
    output logic [DATA_W/8-1:0] flags
);
    localparam int unsigned LANES      = DATA_W / LANE_W;
    localparam int unsigned BYTES_LANE = LANE_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic lane_ovf;
        simd_lane_add #(.W(LANE_W)) u_add (
            .a   (a[i*LANE_W +: LANE_W]),
            .b   (b[i*LANE_W +: LANE_W]),
            .sub (sub),
            .sgn (sgn),
            .sat (sat),
            .res (res[i*LANE_W +: LANE_W]),
            .ovf (lane_ovf)
        );
        assign flags[i*BYTES_LANE +: BYTES_LANE] = {BYTES_LANE{lane_ovf}};
    end

endmodule

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub
    import simd_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              op_sub,
    input  logic              op_signed,
    input  logic              op_sat,
    input  logic [1:0]        lane_size,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [DATA_W/8-1:0] out_flags
);
    localparam int unsigned NBYTES = DATA_W / 8;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic [NBYTES-1:0] flags;
    } out_state_t;

    logic [DATA_W-1:0] bank_res [NUM_SIZES];
    logic [NBYTES-1:0] bank_flg [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        simd_lane_bank #(
            .DATA_W (DATA_W),
            .LANE_W (size_width(k))
        ) u_bank (
            .a     (opa),
            .b     (opb),
            .sub   (op_sub),
            .sgn   (op_signed),
            .sat   (op_sat),
            .res   (bank_res[k]),
            .flags (bank_flg[k])
        );
    end

    out_state_t st_d, st_q;
    lane_size_e size_sel;

    always_comb begin
        size_sel = lane_size_e'(lane_size);
        st_d     = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            unique case (size_sel)
                LSZ_8: begin
                    st_d.result = bank_res[0];
                    st_d.flags  = bank_flg[0];
                end
                LSZ_16: begin
                    st_d.result = bank_res[1];
                    st_d.flags  = bank_flg[1];
                end
                default: begin
                    st_d.result = bank_res[2];
                    st_d.flags  = bank_flg[2];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_flags  = st_q.flags;

endmodule

// File: rtl/simd_sat_addsub_chk.sv
module simd_sat_addsub_chk #(
    parameter int unsigned DATA_W = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                op_sub,
    input logic                op_signed,
    input logic                op_sat,
    input logic [1:0]          lane_size,
    input logic                out_valid,
    input logic [DATA_W-1:0]   out_result,
    input logic [DATA_W/8-1:0] out_flags
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0 && out_flags == '0)); // R8

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_flags))); // R7

    AST_HALF_FLAG_PAIR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_size == 2'd1) |=> (out_flags[1] == out_flags[0])); // R6

    AST_WORD_FLAG_GROUP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_size[1]) |=> (out_flags[3:0] == 4'h0 || out_flags[3:0] == 4'hF)); // R6

    AST_UNS_ADD_CEIL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sat && !op_signed && !op_sub && lane_size == 2'd0)
        |=> (!out_flags[0] || out_result[7:0] == 8'hFF)); // R3

    AST_UNS_SUB_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sat && !op_signed && op_sub && lane_size == 2'd0)
        |=> (!out_flags[0] || out_result[7:0] == 8'h00)); // R4

    AST_SGN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sat && op_signed && lane_size == 2'd0)
        |=> (!out_flags[0] || out_result[7:0] == 8'h7F || out_result[7:0] == 8'h80)); // R5

endmodule

bind simd_sat_addsub simd_sat_addsub_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_sub     (op_sub),
    .op_signed  (op_signed),
    .op_sat     (op_sat),
    .lane_size  (lane_size),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_flags  (out_flags)
);

// File: tb/simd_sat_addsub_bench.sv
`timescale 1ns/1ps
module simd_sat_addsub_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] opa, opb;
    logic        op_sub, op_signed, op_sat;
    logic [1:0]  lane_size;
    logic        out_valid;
    logic [63:0] out_result;
    logic [7:0]  out_flags;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    logic [63:0] last_res;
    logic [7:0]  last_flg;

    always #4 clk = ~clk;

    simd_sat_addsub u_simd_sat_addsub (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .opa        (opa),
        .opb        (opb),
        .op_sub     (op_sub),
        .op_signed  (op_signed),
        .op_sat     (op_sat),
        .lane_size  (lane_size),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_flags  (out_flags)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    function automatic void ref_calc(
        input  logic [63:0] a, b,
        input  bit sub, sgn, sat,
        input  logic [1:0] sz,
        output logic [63:0] r,
        output logic [7:0]  f
    );
        int n;
        longint mask, ua, ub, va, vb, ex, lo, hi, o;
        bit ov;
        n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (64'sd1 <<< n) - 64'sd1;
        r = '0;
        f = '0;
        for (int i = 0; i < 64 / n; i++) begin
            ua = longint'(a >> (i * n)) & mask;
            ub = longint'(b >> (i * n)) & mask;
            if (sgn) begin
                va = (ua >= (64'sd1 <<< (n - 1))) ? ua - (64'sd1 <<< n) : ua;
                vb = (ub >= (64'sd1 <<< (n - 1))) ? ub - (64'sd1 <<< n) : ub;
                lo = -(64'sd1 <<< (n - 1));
                hi = (64'sd1 <<< (n - 1)) - 64'sd1;
            end else begin
                va = ua;
                vb = ub;
                lo = 0;
                hi = mask;
            end
            ex = sub ? va - vb : va + vb;
            ov = (ex < lo) || (ex > hi);
            o  = (ov && sat) ? ((ex > hi) ? hi : lo) : ex;
            r  = r | ((64'(o) & 64'(mask)) << (i * n));
            for (int j = 0; j < n / 8; j++) f[i * (n / 8) + j] = ov;
        end
    endfunction

    function automatic string mode_tag(input bit sub, sgn, sat);
        if (!sat) return "R2";
        if (sgn)  return "R5";
        return sub ? "R4" : "R3";
    endfunction

    task automatic do_op(input logic [63:0] a, b, input bit sub, sgn, sat,
                         input logic [1:0] sz, input string tag);
        logic [63:0] er;
        logic [7:0]  ef;
        ref_calc(a, b, sub, sgn, sat, sz, er, ef);
        opa = a; opb = b; op_sub = sub; op_signed = sgn; op_sat = sat;
        lane_size = sz; in_valid = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b1) begin
            n_fails++;
            $display("FAIL R7 out_valid actual=%b expected=1", out_valid);
        end
        n_checks++;
        if (out_result !== er) begin
            n_fails++;
            $display("FAIL %s result actual=%h expected=%h (a=%h b=%h sz=%0d sub=%0b sgn=%0b sat=%0b)",
                     tag, out_result, er, a, b, sz, sub, sgn, sat);
        end
        n_checks++;
        if (out_flags !== ef) begin
            n_fails++;
            $display("FAIL R6 flags actual=%b expected=%b", out_flags, ef);
        end
        last_res = er;
        last_flg = ef;
    endtask

    initial begin
        logic [63:0] ra, rb;
        bit rsub, rsgn, rsat;
        logic [1:0] rsz;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; in_valid = 1'b0; opa = '0; opb = '0;
        op_sub = 0; op_signed = 0; op_sat = 0; lane_size = 0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_result !== 64'h0 || out_flags !== 8'h0) begin
            n_fails++;
            $display("FAIL R8 reset actual=%b/%h/%b expected=0/0/0", out_valid, out_result, out_flags);
        end
        rst = 1'b0;
        @(negedge clk);

        // R3 / R9: FE+34 and ED+56 clamp, 78+05 stays 7D
        do_op(64'h0000_0000_0078_EDFE, 64'h0000_0000_0005_5634, 0, 0, 1, 2'd0, "R3");
        n_checks++;
        if (out_result[23:16] !== 8'h7D) begin
            n_fails++;
            $display("FAIL R9 in-range byte actual=%h expected=7d", out_result[23:16]);
        end
        // R1: borrow out of low 32-bit lane must not reach upper lane (wrap)
        do_op(64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 1, 0, 0, 2'd2, "R1");
        do_op(64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 1, 0, 0, 2'd3, "R1");
        // R1: carry out of low 16-bit lane does not reach lane 1
        do_op(64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 0, 0, 0, 2'd1, "R1");
        // R4: unsigned clamp to zero
        do_op(64'h0010_2030_4050_6070, 64'h0011_1F31_3F51_5F71, 1, 0, 1, 2'd0, "R4");
        // R5: signed limits, bytes/halves/words
        do_op(64'h7F80_7F80_0102_8001, 64'h0101_80FF_7F7F_FFFF, 0, 1, 1, 2'd0, "R5");
        do_op(64'h8000_7FFF_0000_8000, 64'h0001_FFFF_8000_0001, 1, 1, 1, 2'd1, "R5");
        do_op(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 0, 1, 1, 2'd2, "R5");
        // R2: wrap, flags still raised
        do_op(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 0, 1, 0, 2'd2, "R2");

        // R7: idle cycle holds result, no valid
        opa = ~opa; in_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_result !== last_res || out_flags !== last_flg) begin
            n_fails++;
            $display("FAIL R7 hold actual=%b/%h/%b expected=0/%h/%b",
                     out_valid, out_result, out_flags, last_res, last_flg);
        end

        for (int t = 0; t < 3000; t++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (($urandom % 4) == 0) rb = ~ra;
            rsub = $urandom; rsgn = $urandom; rsat = $urandom;
            rsz  = $urandom;
            do_op(ra, rb, rsub, rsgn, rsat, rsz, mode_tag(rsub, rsgn, rsat));
            if (($urandom % 8) == 0) begin
                in_valid = 1'b0;
                opb = ~opb;
                @(negedge clk);
                n_checks++;
                if (out_valid !== 1'b0 || out_result !== last_res) begin
                    n_fails++;
                    $display("FAIL R7 idle actual=%b/%h expected=0/%h",
                             out_valid, out_result, last_res);
                end
            end
        end

        // R8: reset mid-stream clears outputs
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_result !== 64'h0 || out_flags !== 8'h0) begin
            n_fails++;
            $display("FAIL R8 mid reset actual=%b/%h/%b expected=0/0/0", out_valid, out_result, out_flags);
        end
        rst = 1'b0; in_valid = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule